// File: doc/BRIEF.md
# I2C Target Byte Engine with Clock Stretching

This block is the bus-facing half of an I2C target that uses a 7-bit address. It samples the SCL and SDA pins through synchronizers and finds Start, Restart and Stop conditions in the system clock domain. It compares the first byte of each transfer with its own address, then moves data bytes MSB first through a single byte buffer. It drives both lines only through open-drain pull-down enables.

A local host sees the transfer through a small set of ports. These are a buffer read and write port, a clock-release pulse, four sticky flags that the host clears by pulse, and the live status bits: Start, Stop, data/address, read/write, ACK status and buffer full. The engine answers ACK or NACK from the buffer state. It holds SCL low whenever the host must act before the next byte. It drops out of a transfer when the controller sends NACK or when another driver overrides a bit it released.

Top module: `i2c_target_engine`

## Requirements
- R1: After reset both `start_seen` and `stop_seen` are 0. A Start (SDA falls while SCL is high) sets `start_seen` and clears `stop_seen`. A Stop (SDA rises while SCL is high) sets `stop_seen` and clears `start_seen`, but only when SCL has been low at least once since the last Start. Both Start and Stop clear `rw_flag`.
- R2: The first byte after a Start is an address byte. Bits 7..1 of that byte are compared with `own_addr`. On a mismatch the engine sends no ACK, raises no interrupt, and ignores every later byte until the next Start.
- R3: On a matching address with bit 0 = 0, or on a later data byte, the engine pulls SDA low during the ninth clock, loads the byte into the buffer (`rd_data`), sets `buf_full`, and sets `irq` on the ninth falling edge. `rw_flag` copies address bit 0. `data_flag` is 0 for an address byte and 1 for a data byte. A `rd_en` pulse clears `buf_full`.
- R4: A received byte that completes while `buf_full` = 1 sets `ovf`, leaves the buffer unchanged and is not acknowledged. While `ovf` = 1 and the buffer is empty, a byte is loaded and sets `buf_full` but is still not acknowledged.
- R5: With `stretch_en` = 1, the engine holds SCL low (`scl_oe` = 1) after the ninth clock of every received byte until the host pulses `release_clk`. With `stretch_en` = 0 it does not hold SCL.
- R6: On a matching address with bit 0 = 1 the engine ACKs, then holds SCL low. A `wr_en` pulse loads the buffer and sets `buf_full`. After `release_clk`, the bits go out MSB first and change only while SCL is low. `buf_full` clears after the eighth bit.
- R7: During transmit, the SDA level at the ninth rising edge is stored in `ack_stat`. On ACK (0) the engine holds SCL again after the ninth clock. On NACK (1) it does not hold SCL. It still sets `irq`, clears `rw_flag`, and ignores further clocks until the next Start.
- R8: A `wr_en` pulse while a transmit byte is pending (`buf_full` = 1) sets `wcol` and leaves the buffer unchanged. Host writes outside a read transfer are ignored.
- R9: If SDA reads low at a rising SCL edge while the engine is releasing it for a transmit 1 bit, the engine sets `bcol`, stops driving both lines and returns to idle.
- R10: A Restart in the middle of a transfer resets the engine exactly as a Start does, and the next byte is treated as an address.
- R11: The `clr_flags` bits clear sticky flags: bit 0 clears `irq`, bit 1 clears `ovf`, bit 2 clears `wcol`, bit 3 clears `bcol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| own_addr | input | 7 | 7-bit target address |
| stretch_en | input | 1 | Stretch after each received byte |
| wr_en | input | 1 | Host buffer write strobe |
| wr_data | input | 8 | Host transmit byte |
| rd_en | input | 1 | Host buffer read strobe, clears buffer full |
| rd_data | output | 8 | Buffer contents |
| release_clk | input | 1 | Pulse to release a held SCL |
| clr_flags | input | 4 | Clear pulses for irq, ovf, wcol, bcol |
| buf_full | output | 1 | Buffer holds an unread or unsent byte |
| ovf | output | 1 | Receive overflow flag |
| wcol | output | 1 | Write collision flag |
| bcol | output | 1 | Bus collision flag |
| start_seen | output | 1 | Start was the last bus condition |
| stop_seen | output | 1 | Stop was the last bus condition |
| data_flag | output | 1 | Last byte was data (1) or address (0) |
| rw_flag | output | 1 | Current transfer is a read |
| ack_stat | output | 1 | Controller ACK bit of last transmit byte |
| irq | output | 1 | Byte event interrupt flag |

## Verification
Every result lags the bus action that causes it by the two synchronizer stages plus one edge-detect register, so it lands on the third or fourth clock edge after the pin changes. The controller model keeps each SCL phase eight clocks long. It checks status only after waiting at least four cycles past the relevant SCL edge, and it samples SDA at the end of the high phase. Interrupt results are matched by a monitor. It waits for `irq` to rise, reads the buffer and status half a cycle later, and compares them with the item the driver queued before sending that byte.

// File: rtl/i2c_target_engine.sv
module i2c_target_engine #(
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [6:0] own_addr,
  input  logic       stretch_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       release_clk,
  input  logic [3:0] clr_flags,
  output logic       buf_full,
  output logic       ovf,
  output logic       wcol,
  output logic       bcol,
  output logic       start_seen,
  output logic       stop_seen,
  output logic       data_flag,
  output logic       rw_flag,
  output logic       ack_stat,
  output logic       irq
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_RX, ST_TX} st_t;

  logic [SYNC_LEN-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d, scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic low_seen, ackph, ack_out, hold;
  logic [3:0] cnt;
  logic [7:0] sr, buf_q;
  st_t state;

  assign scl_s     = scl_sync[SYNC_LEN-1];
  assign sda_s     = sda_sync[SYNC_LEN-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s & low_seen;

  assign scl_oe  = hold;
  assign sda_oe  = ackph ? ack_out : (state == ST_TX && buf_full && !sr[7]);
  assign rd_data = buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_LEN-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_LEN-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sr         <= '0;
      buf_q      <= '0;
      low_seen   <= 1'b0;
      ackph      <= 1'b0;
      ack_out    <= 1'b0;
      hold       <= 1'b0;
      buf_full   <= 1'b0;
      ovf        <= 1'b0;
      wcol       <= 1'b0;
      bcol       <= 1'b0;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      data_flag  <= 1'b0;
      rw_flag    <= 1'b0;
      ack_stat   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (clr_flags[0]) irq  <= 1'b0;
      if (clr_flags[1]) ovf  <= 1'b0;
      if (clr_flags[2]) wcol <= 1'b0;
      if (clr_flags[3]) bcol <= 1'b0;
      if (release_clk) hold <= 1'b0;
      if (rd_en && state != ST_TX) buf_full <= 1'b0;
      if (wr_en && state == ST_TX) begin
        if (buf_full) wcol <= 1'b1;
        else begin
          buf_q    <= wr_data;
          sr       <= wr_data;
          buf_full <= 1'b1;
        end
      end
      if (!scl_s) low_seen <= 1'b1;

      if (start_det) begin
        state      <= ST_ADDR;
        cnt        <= '0;
        ackph      <= 1'b0;
        ack_out    <= 1'b0;
        hold       <= 1'b0;
        low_seen   <= 1'b0;
        start_seen <= 1'b1;
        stop_seen  <= 1'b0;
        rw_flag    <= 1'b0;
      end else if (stop_det) begin
        state      <= ST_IDLE;
        cnt        <= '0;
        ackph      <= 1'b0;
        ack_out    <= 1'b0;
        hold       <= 1'b0;
        start_seen <= 1'b0;
        stop_seen  <= 1'b1;
        rw_flag    <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (ackph) begin
            if (state == ST_TX && data_flag) ack_stat <= sda_s;
          end else begin
            cnt <= cnt + 4'd1;
            if (state == ST_TX) begin
              if (buf_full && sr[7] && !sda_s) begin
                bcol  <= 1'b1;
                state <= ST_IDLE;
                cnt   <= '0;
              end
            end else begin
              sr <= {sr[6:0], sda_s};
            end
          end
        end else if (scl_fall) begin
          if (ackph) begin
            ackph   <= 1'b0;
            ack_out <= 1'b0;
            cnt     <= '0;
            irq     <= 1'b1;
            if (state == ST_TX) begin
              if (!data_flag || !ack_stat) hold <= 1'b1;
              else begin
                state   <= ST_IDLE;
                rw_flag <= 1'b0;
              end
            end else begin
              hold <= stretch_en;
            end
          end else if (cnt == 4'd8) begin
            ackph <= 1'b1;
            case (state)
              ST_ADDR: begin
                if (sr[7:1] == own_addr) begin
                  rw_flag   <= sr[0];
                  data_flag <= 1'b0;
                  if (sr[0]) begin
                    state   <= ST_TX;
                    buf_q   <= sr;
                    ack_out <= 1'b1;
                  end else begin
                    state <= ST_RX;
                    if (buf_full) begin
                      ovf     <= 1'b1;
                      ack_out <= 1'b0;
                    end else begin
                      buf_q    <= sr;
                      buf_full <= 1'b1;
                      ack_out  <= !ovf;
                    end
                  end
                end else begin
                  state <= ST_IDLE;
                  ackph <= 1'b0;
                  cnt   <= '0;
                end
              end
              ST_RX: begin
                data_flag <= 1'b1;
                if (buf_full) begin
                  ovf     <= 1'b1;
                  ack_out <= 1'b0;
                end else begin
                  buf_q    <= sr;
                  buf_full <= 1'b1;
                  ack_out  <= !ovf;
                end
              end
              default: begin
                data_flag <= 1'b1;
                buf_full  <= 1'b0;
                ack_out   <= 1'b0;
              end
            endcase
          end else if (state == ST_TX && cnt != 4'd0) begin
            sr <= {sr[6:0], 1'b0};
          end
        end
      end
    end
  end

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(start_seen && stop_seen)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) state == ST_IDLE |-> !sda_oe && !scl_oe); // R7
  AST_OVF_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf) |-> $stable(buf_q)); // R4
  AST_HOLD_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(scl_oe) |-> !scl_s); // R5
  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !scl_s); // R6
  AST_WCOL_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n) $rose(wcol) |-> $stable(buf_q)); // R8
  AST_BCOL_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(bcol) |-> state == ST_IDLE); // R9

endmodule

// File: tb/test_i2c_target_engine.sv
`timescale 1ns/1ps
module test_i2c_target_engine;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, scl_m, sda_m, stretch_en, wr_en, rd_en, release_clk, mon_clr;
  logic [7:0] wr_data, rd_data;
  logic [3:0] drv_clr;
  logic [6:0] own_addr;
  logic scl_oe, sda_oe, buf_full, ovf, wcol, bcol, start_seen, stop_seen;
  logic data_flag, rw_flag, ack_stat, irq;
  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_q[$];
  string tag_q[$];

  i2c_target_engine i_i2c_target_engine (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .stretch_en(stretch_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .release_clk(release_clk), .clr_flags({drv_clr[3:1], drv_clr[0] | mon_clr}),
    .buf_full(buf_full), .ovf(ovf), .wcol(wcol), .bcol(bcol),
    .start_seen(start_seen), .stop_seen(stop_seen), .data_flag(data_flag),
    .rw_flag(rw_flag), .ack_stat(ack_stat), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_irq(input string req, input logic rw, input logic da, input logic [7:0] b);
    exp_q.push_back({rw, da, b});
    tag_q.push_back(req);
  endtask

  task automatic clk_bit(output logic s);
    idle(Q);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    idle(Q);
    s = sda_line;
    scl_m = 1'b0;
    idle(2);
  endtask

  task automatic start_cond();
    sda_m = 1'b1;
    idle(Q);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    idle(Q);
    sda_m = 1'b0;
    idle(Q);
    scl_m = 1'b0;
    idle(2);
  endtask

  task automatic stop_cond();
    sda_m = 1'b0;
    idle(Q);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    idle(Q);
    sda_m = 1'b1;
    idle(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      clk_bit(s);
    end
    sda_m = 1'b1;
    clk_bit(nack);
  endtask

  task automatic read_byte(input logic ack_bit, output logic [7:0] b);
    logic s;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(s);
      b[i] = s;
    end
    sda_m = ack_bit;
    clk_bit(s);
    sda_m = 1'b1;
  endtask

  task automatic host_rd();
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic host_wr(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic host_release();
    release_clk = 1'b1; @(negedge clk); release_clk = 1'b0;
  endtask

  task automatic host_clr(input logic [3:0] m);
    drv_clr = m; @(negedge clk); drv_clr = 4'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [9:0] e;
    string t;
    mon_clr = 1'b0;
    forever begin
      @(posedge irq);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R3 unexpected irq actual %0h expected none", {rw_flag, data_flag, rd_data});
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {rw_flag, data_flag, rd_data}, e);
      end
      mon_clr = 1'b1;
      @(negedge clk);
      mon_clr = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic n;
    logic [7:0] b;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; stretch_en = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; release_clk = 1'b0; drv_clr = 4'b0;
    wr_data = 8'h00; own_addr = 7'h2A;
    idle(4);
    chk("R1 reset start/stop", {start_seen, stop_seen}, 2'b00);
    chk("R11 reset flags", {irq, ovf, wcol, bcol, buf_full}, 5'b0);
    chk("R5 reset line drive", {scl_oe, sda_oe}, 2'b00);
    rst_n = 1'b1;
    idle(4);

    // write transfer, no stretching
    start_cond();
    chk("R1 start sets", {start_seen, stop_seen}, 2'b10);
    expect_irq("R3 address write", 1'b0, 1'b0, 8'h54);
    send_byte(8'h54, n);
    chk("R2 address ack", n, 1'b0);
    idle(4);
    chk("R5 no hold without stretch", scl_oe, 1'b0);
    host_rd();
    expect_irq("R3 data byte", 1'b0, 1'b1, 8'h96);
    send_byte(8'h96, n);
    chk("R3 data ack", n, 1'b0);
    chk("R3 buffer full", {buf_full, rd_data}, {1'b1, 8'h96});
    expect_irq("R4 overflow keeps buffer", 1'b0, 1'b1, 8'h96);
    send_byte(8'h11, n);
    chk("R4 overflow nack", n, 1'b1);
    chk("R4 overflow flag", {ovf, rd_data}, {1'b1, 8'h96});
    host_rd();
    chk("R3 read clears full", buf_full, 1'b0);
    expect_irq("R4 loaded while ovf", 1'b0, 1'b1, 8'h22);
    send_byte(8'h22, n);
    chk("R4 nack while ovf", n, 1'b1);
    chk("R4 loaded while ovf", {buf_full, rd_data}, {1'b1, 8'h22});
    host_clr(4'b0010);
    chk("R11 ovf clear", ovf, 1'b0);
    host_rd();
    expect_irq("R3 ack after clear", 1'b0, 1'b1, 8'h33);
    send_byte(8'h33, n);
    chk("R3 ack after ovf clear", n, 1'b0);
    host_rd();
    stop_cond();
    chk("R1 stop sets", {start_seen, stop_seen, rw_flag}, 3'b010);

    // address mismatch
    start_cond();
    send_byte(8'h40, n);
    chk("R2 mismatch nack", n, 1'b1);
    send_byte(8'h55, n);
    chk("R2 later byte ignored", {n, buf_full}, 2'b10);
    stop_cond();
    sda_m = 1'b0;
    idle(Q);
    sda_m = 1'b1;
    idle(Q);
    chk("R1 stop needs scl low", {start_seen, stop_seen}, 2'b10);

    // stretched receive, then restart into read
    stretch_en = 1'b1;
    start_cond();
    expect_irq("R3 address write stretched", 1'b0, 1'b0, 8'h54);
    send_byte(8'h54, n);
    idle(4);
    chk("R5 hold after address", {n, scl_oe}, 2'b01);
    host_rd();
    host_release();
    idle(2);
    chk("R5 release drops hold", scl_oe, 1'b0);
    expect_irq("R3 data stretched", 1'b0, 1'b1, 8'h5A);
    send_byte(8'h5A, n);
    idle(4);
    chk("R5 hold after data", {n, scl_oe}, 2'b01);
    host_rd();
    host_release();
    start_cond();
    chk("R10 restart status", {start_seen, stop_seen}, 2'b10);
    expect_irq("R10 read address after restart", 1'b1, 1'b0, 8'h55);
    send_byte(8'h55, n);
    idle(4);
    chk("R6 read ack and hold", {n, scl_oe, rw_flag}, 3'b011);
    host_wr(8'hA5);
    host_wr(8'h3C);
    chk("R8 write collision", {wcol, rd_data, buf_full}, {1'b1, 8'hA5, 1'b1});
    host_clr(4'b0100);
    chk("R11 wcol clear", wcol, 1'b0);
    host_release();
    expect_irq("R6 transmit byte", 1'b1, 1'b1, 8'hA5);
    read_byte(1'b0, b);
    chk("R6 transmitted data", b, 8'hA5);
    idle(4);
    chk("R7 ack hold", {ack_stat, scl_oe, buf_full}, 3'b010);
    host_wr(8'h69);
    host_release();
    expect_irq("R7 nack still interrupts", 1'b0, 1'b1, 8'h69);
    read_byte(1'b1, b);
    chk("R6 second byte", b, 8'h69);
    idle(4);
    chk("R7 nack releases", {ack_stat, scl_oe, rw_flag}, 3'b100);
    read_byte(1'b1, b);
    chk("R7 idle after nack", {b, sda_oe}, {8'hFF, 1'b0});
    stop_cond();

    // bus collision on a released bit
    start_cond();
    expect_irq("R9 read address", 1'b1, 1'b0, 8'h55);
    send_byte(8'h55, n);
    idle(4);
    host_wr(8'hC3);
    host_release();
    sda_m = 1'b0;
    clk_bit(n);
    sda_m = 1'b1;
    idle(4);
    chk("R9 collision flag", {bcol, sda_oe, scl_oe}, 3'b100);
    host_clr(4'b1000);
    chk("R11 bcol clear", bcol, 1'b0);
    stop_cond();
    host_rd();
    idle(20);
    chk("R3 all interrupts seen", exp_q.size(), 0);
    finish_run();
  end
endmodule